// File: doc/BRIEF.md
# DRAM Event Monitor

This block counts activity reported by a DRAM controller. The controller drives a vector of one-cycle event pulses, plus a dedicated pulse for each completed DRAM read and each completed DRAM write. Software programs and reads the block through a simple 64-bit register bus with byte offsets. Each bus access takes one cycle, and read data is registered.

There are eight programmable counters. Each one has a configuration register that holds an enable bit and an event-select bitmap. A counter advances by one in any cycle in which at least one of its selected event lines pulses. A single selection can span several adjacent lines; for example, a four-bit field counts any of four related events. These counters run only while a small run-control state machine is in its counting state, and they saturate at their maximum. The two free-running counters, one for reads and one for writes, do not depend on the state machine. Each has its own enable bit and its own clear bit. Their low bits wrap, and their top bit records a sticky overflow.

The run-control state machine has three states. `ST_IDLE` is entered at reset. `ST_RUN` is the counting state. `ST_DONE` means a measurement has ended. It has three transitions. *start* goes from `ST_IDLE` to `ST_RUN`. *end* goes from `ST_RUN` to `ST_DONE`. *restart* goes from `ST_DONE` or `ST_RUN` to `ST_RUN`. Every accepted start or restart zeroes all programmable counter values in the same clock edge. If start and end are requested in the same cycle, start wins.

Top module: `dram_evt_monitor`

## Requirements
- R1: After reset, every register reads zero: the mode, the configurations, the counter values, the free-run enables and the free-run counts. The state machine is in `ST_IDLE`, so the active bit and the done bit both read 0.
- R2: Offset 0x8020 bit 0 is the manual-mode bit, and it reads back. A start write made while this bit is 0 is ignored: the state and the counter values stay unchanged.
- R3: Writing a 1 to bit 0 of offset 0x8028 in manual mode enters `ST_RUN`. It also zeroes every programmable counter value in that edge. While in `ST_RUN`, a read of 0x8028 returns 2 (bit 1 is the active bit).
- R4: Writing a 1 to bit 0 of offset 0x8030 while in `ST_RUN` enters `ST_DONE`. In `ST_DONE`, offset 0x8038 bit 0 reads 1, the active bit reads 0, and the programmable counters hold their values. An end write made in any other state is ignored. Offset 0x8030 reads zero.
- R5: Configuration register n (n = 0..7) is at 0x8040 + 8·n. Bit 63 is the enable and bits 54:0 are the event bitmap. Bits 62:55 read zero.
- R6: Programmable counter n adds exactly 1 in each cycle where three conditions hold: its enable is set, the state is `ST_RUN`, and its bitmap ANDed with the event vector is non-zero. It adds 1 even when several selected lines pulse together.
- R7: A programmable counter that has reached all ones (2^CNT_W − 1) stays there until the next start.
- R8: The value of counter n reads at 0x8080 + 8·n, zero-extended. Writes to these offsets have no effect.
- R9: Offset 0x80C0 holds the free-run enables: bit 0 enables the write counter and bit 1 enables the read counter. An enabled counter counts its pulse in every state-machine state.
- R10: A write to offset 0x80C8 clears the write counter when bit 0 is set and the read counter when bit 1 is set. A clear wins over a pulse in the same cycle. The offset reads zero.
- R11: The write count reads at 0x80D0 and the read count at 0x80D8. Bits CNT_W−2:0 wrap. Bit CNT_W−1 (bit 48 by default) is set on a wrap and stays set until cleared.
- R12: Reads of unmapped or unaligned offsets return zero, and writes to them change nothing.
- R13: `bus_rdata` takes the addressed value on the clock edge where `bus_rd` is sampled high. It then holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (16) | Byte offset of the access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| evt_in | input | NUM_EVT (55) | One-cycle event pulses from the controller |
| dram_rd_pulse | input | 1 | One pulse per completed DRAM read |
| dram_wr_pulse | input | 1 | One pulse per completed DRAM write |

## Verification
Every wrong internal state shows up at the bus within two cycles of the next read of the affected register. This holds whether the fault is a state machine stuck outside `ST_RUN`, a counter that misses its clear on start, a bitmap compare against the wrong lines, or a lost overflow bit. Each appears as a count or status value that differs from the reference the bench updates cycle by cycle. The bench reads every register class both after directed sequences and at random points in a long random run. It uses a narrow counter width so that saturation, wrap and sticky overflow are reached within a few hundred cycles.

// File: rtl/dmon_pkg.sv
package dmon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

    localparam logic [15:0] OFS_MODE  = 16'h8020;
    localparam logic [15:0] OFS_START = 16'h8028;
    localparam logic [15:0] OFS_END   = 16'h8030;
    localparam logic [15:0] OFS_STAT  = 16'h8038;
    localparam logic [15:0] OFS_CFG0  = 16'h8040;
    localparam logic [15:0] OFS_VAL0  = 16'h8080;
    localparam logic [15:0] OFS_FREN  = 16'h80C0;
    localparam logic [15:0] OFS_FRCLR = 16'h80C8;
    localparam logic [15:0] OFS_FRWR  = 16'h80D0;
    localparam logic [15:0] OFS_FRRD  = 16'h80D8;

    localparam int REG_W  = 64;
    localparam int EN_BIT = 63;

endpackage

// File: rtl/dmon_ctrl.sv
module dmon_ctrl
    import dmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic end_req,
    output logic run,
    output logic done,
    output logic clr_all
);

    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = ST_RUN;
            ST_RUN: begin
                if (start_req)    state_d = ST_RUN;
                else if (end_req) state_d = ST_DONE;
            end
            ST_DONE: if (start_req) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run     = (state_q == ST_RUN);
        done    = (state_q == ST_DONE);
        clr_all = start_req;
    end

    assert_start_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> run && !done);

    assert_end_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (end_req && run && !start_req) |=> done && !run);

    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_req) |=> done);

    assert_idle_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !done && !start_req) |=> !run && !done);

endmodule

// File: rtl/dmon_prog_cnt.sv
module dmon_prog_cnt
    import dmon_pkg::*;
#(
    parameter int CNT_W   = 49,
    parameter int NUM_EVT = 55
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [REG_W-1:0]   cfg_wdata,
    input  logic               clr,
    input  logic               run,
    input  logic [NUM_EVT-1:0] evt,
    output logic [REG_W-1:0]   cfg_q,
    output logic [CNT_W-1:0]   cnt_q
);

    localparam int PAD_W = EN_BIT - NUM_EVT;

    logic               en_q;
    logic [NUM_EVT-1:0] map_q;
    logic               hit;
    logic               at_max;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            map_q <= '0;
        end else if (cfg_we) begin
            en_q  <= cfg_wdata[EN_BIT];
            map_q <= cfg_wdata[NUM_EVT-1:0];
        end
    end

    assign cfg_q  = {en_q, {PAD_W{1'b0}}, map_q};
    assign hit    = en_q && run && (|(map_q & evt));
    assign at_max = &cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clr)            cnt_q <= '0;
        else if (hit && !at_max) cnt_q <= cnt_q + 1'b1;
    end

    assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_q && !clr) |=> &cnt_q);

    assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q >= $past(cnt_q)) && ((cnt_q - $past(cnt_q)) <= 1));

    assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/dmon_free_cnt.sv
module dmon_free_cnt #(
    parameter int CNT_W = 49
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             pulse,
    output logic [CNT_W-1:0] val_q
);

    localparam int LOW_W = CNT_W - 1;

    logic [LOW_W-1:0] low_q;
    logic             ovf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr) begin
            low_q <= '0;
            ovf_q <= 1'b0;
        end else if (en && pulse) begin
            low_q <= low_q + 1'b1;
            if (&low_q) ovf_q <= 1'b1;
        end
    end

    assign val_q = {ovf_q, low_q};

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (val_q[CNT_W-1] && !clr) |=> val_q[CNT_W-1]);

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> val_q == '0);

    assert_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(val_q));

endmodule

// File: rtl/dram_evt_monitor.sv
module dram_evt_monitor
    import dmon_pkg::*;
#(
    parameter int NUM_PROG = 8,
    parameter int NUM_EVT  = 55,
    parameter int CNT_W    = 49,
    parameter int ADDR_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               dram_rd_pulse,
    input  logic               dram_wr_pulse
);

    localparam int NUM_FR = 2;

    logic sel_mode, sel_start, sel_end, sel_stat;
    logic sel_fren, sel_frclr, sel_frwr, sel_frrd;
    logic [NUM_PROG-1:0] cfg_sel, val_sel;

    assign sel_mode  = (bus_addr == ADDR_W'(OFS_MODE));
    assign sel_start = (bus_addr == ADDR_W'(OFS_START));
    assign sel_end   = (bus_addr == ADDR_W'(OFS_END));
    assign sel_stat  = (bus_addr == ADDR_W'(OFS_STAT));
    assign sel_fren  = (bus_addr == ADDR_W'(OFS_FREN));
    assign sel_frclr = (bus_addr == ADDR_W'(OFS_FRCLR));
    assign sel_frwr  = (bus_addr == ADDR_W'(OFS_FRWR));
    assign sel_frrd  = (bus_addr == ADDR_W'(OFS_FRRD));

    logic              mode_q;
    logic [NUM_FR-1:0] fr_en_q;
    logic              start_req, end_req;
    logic              run, done, clr_all;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            fr_en_q <= '0;
        end else if (bus_wr) begin
            if (sel_mode) mode_q  <= bus_wdata[0];
            if (sel_fren) fr_en_q <= bus_wdata[NUM_FR-1:0];
        end
    end

    assign start_req = bus_wr && sel_start && bus_wdata[0] && mode_q;
    assign end_req   = bus_wr && sel_end && bus_wdata[0];

    dmon_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .end_req   (end_req),
        .run       (run),
        .done      (done),
        .clr_all   (clr_all)
    );

    logic [REG_W-1:0] cfg_q [NUM_PROG];
    logic [CNT_W-1:0] cnt_q [NUM_PROG];

    for (genvar n = 0; n < NUM_PROG; n++) begin : g_prog
        localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(OFS_CFG0) + ADDR_W'(8 * n);
        localparam logic [ADDR_W-1:0] VAL_A = ADDR_W'(OFS_VAL0) + ADDR_W'(8 * n);

        assign cfg_sel[n] = (bus_addr == CFG_A);
        assign val_sel[n] = (bus_addr == VAL_A);

        dmon_prog_cnt #(
            .CNT_W   (CNT_W),
            .NUM_EVT (NUM_EVT)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (bus_wr && cfg_sel[n]),
            .cfg_wdata (bus_wdata),
            .clr       (clr_all),
            .run       (run),
            .evt       (evt_in),
            .cfg_q     (cfg_q[n]),
            .cnt_q     (cnt_q[n])
        );
    end

    logic [NUM_FR-1:0] fr_pulse, fr_clr;
    logic [CNT_W-1:0]  fr_val [NUM_FR];

    assign fr_pulse = {dram_rd_pulse, dram_wr_pulse};
    assign fr_clr   = (bus_wr && sel_frclr) ? bus_wdata[NUM_FR-1:0] : '0;

    for (genvar f = 0; f < NUM_FR; f++) begin : g_free
        dmon_free_cnt #(
            .CNT_W (CNT_W)
        ) u_fr (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (fr_en_q[f]),
            .clr   (fr_clr[f]),
            .pulse (fr_pulse[f]),
            .val_q (fr_val[f])
        );
    end

    logic [REG_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (sel_mode)  rd_mux = REG_W'(mode_q);
        if (sel_start) rd_mux = REG_W'({run, 1'b0});
        if (sel_stat)  rd_mux = REG_W'(done);
        if (sel_fren)  rd_mux = REG_W'(fr_en_q);
        if (sel_frwr)  rd_mux = REG_W'(fr_val[0]);
        if (sel_frrd)  rd_mux = REG_W'(fr_val[1]);
        for (int k = 0; k < NUM_PROG; k++) begin
            if (cfg_sel[k]) rd_mux = cfg_q[k];
            if (val_sel[k]) rd_mux = REG_W'(cnt_q[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_start && !mode_q) |=> ($stable(run) && $stable(done)));

    assert_run_done_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && done));

endmodule

// File: tb/tb_dram_evt_monitor.sv
`timescale 1ns/1ps
module tb_dram_evt_monitor;

    localparam int CW = 8;
    localparam int NE = 55;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic [NE-1:0] evt_in = '0;
    logic          dram_rd_pulse = 1'b0;
    logic          dram_wr_pulse = 1'b0;

    always #5 clk = ~clk;

    dram_evt_monitor #(
        .NUM_PROG (NP),
        .NUM_EVT  (NE),
        .CNT_W    (CW),
        .ADDR_W   (16)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .evt_in        (evt_in),
        .dram_rd_pulse (dram_rd_pulse),
        .dram_wr_pulse (dram_wr_pulse)
    );

    // reference state built from the requirements
    logic [CW-1:0] m_cnt [NP];
    logic          m_en  [NP];
    logic [NE-1:0] m_map [NP];
    logic          m_mode;
    int            m_state;          // 0 idle, 1 run, 2 done
    logic [1:0]    m_fren;
    logic [CW-2:0] m_low [2];
    logic          m_ovf [2];
    logic [63:0]   exp_rd;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_read(input logic [15:0] a);
        logic [63:0] v;
        int n;
        v = '0;
        if (a[2:0] == 3'd0) begin
            if (a == 16'h8020) v = 64'(m_mode);
            else if (a == 16'h8028) v = (m_state == 1) ? 64'd2 : 64'd0;
            else if (a == 16'h8038) v = (m_state == 2) ? 64'd1 : 64'd0;
            else if (a >= 16'h8040 && a < 16'h8080) begin
                n = int'((a - 16'h8040) >> 3);
                v = {m_en[n], 8'b0, m_map[n]};
            end else if (a >= 16'h8080 && a < 16'h80C0) begin
                n = int'((a - 16'h8080) >> 3);
                v = 64'(m_cnt[n]);
            end else if (a == 16'h80C0) v = 64'(m_fren);
            else if (a == 16'h80D0) v = 64'({m_ovf[0], m_low[0]});
            else if (a == 16'h80D8) v = 64'({m_ovf[1], m_low[1]});
        end
        return v;
    endfunction

    task automatic model_step(input bit wr, input logic [15:0] a, input logic [63:0] d,
                              input logic [NE-1:0] e, input bit rp, input bit wp);
        bit start_go, end_go, pl, cl;
        start_go = wr && a == 16'h8028 && d[0] && m_mode;
        end_go   = wr && a == 16'h8030 && d[0] && m_state == 1 && !start_go;
        for (int n = 0; n < NP; n++) begin
            if (start_go) m_cnt[n] = '0;
            else if (m_en[n] && m_state == 1 && |(m_map[n] & e) && m_cnt[n] != {CW{1'b1}})
                m_cnt[n] = m_cnt[n] + 1'b1;
        end
        for (int i = 0; i < 2; i++) begin
            pl = (i == 1) ? rp : wp;
            cl = wr && a == 16'h80C8 && d[i];
            if (cl) begin
                m_low[i] = '0;
                m_ovf[i] = 1'b0;
            end else if (m_fren[i] && pl) begin
                if (&m_low[i]) m_ovf[i] = 1'b1;
                m_low[i] = m_low[i] + 1'b1;
            end
        end
        if (wr && a == 16'h8020) m_mode = d[0];
        if (wr && a == 16'h80C0) m_fren = d[1:0];
        for (int n = 0; n < NP; n++) begin
            if (wr && a == 16'(16'h8040 + 8 * n)) begin
                m_en[n]  = d[63];
                m_map[n] = d[NE-1:0];
            end
        end
        if (start_go) m_state = 1;
        else if (end_go) m_state = 2;
    endtask

    task automatic drive(input bit wr, input bit rd, input logic [15:0] a, input logic [63:0] d,
                         input logic [NE-1:0] e, input bit rp, input bit wp);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        evt_in = e; dram_rd_pulse = rp; dram_wr_pulse = wp;
        if (rd) exp_rd = model_read(a);
        model_step(wr, a, d, e, rp, wp);
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [63:0] d);
        drive(1'b1, 1'b0, a, d, '0, 1'b0, 1'b0);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 16'h0, 64'h0, '0, 1'b0, 1'b0);
    endtask

    task automatic rd_check(input logic [15:0] a, input string tag);
        drive(1'b0, 1'b1, a, 64'h0, '0, 1'b0, 1'b0);
        @(negedge clk);
        check(bus_rdata, exp_rd, tag);
        bus_rd = 1'b0; bus_wr = 1'b0; evt_in = '0;
        dram_rd_pulse = 1'b0; dram_wr_pulse = 1'b0;
    endtask

    task automatic rd_lit(input logic [15:0] a, input logic [63:0] lit, input string tag);
        rd_check(a, tag);
        check(bus_rdata, lit, {tag, " literal"});
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        logic [NE-1:0] sel4;
        void'($urandom(32'd20240611));
        for (int n = 0; n < NP; n++) begin
            m_cnt[n] = '0; m_en[n] = 1'b0; m_map[n] = '0;
        end
        m_mode = 1'b0; m_state = 0; m_fren = '0;
        for (int i = 0; i < 2; i++) begin m_low[i] = '0; m_ovf[i] = 1'b0; end
        exp_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_lit(16'h8020, 64'h0, "R1 mode");
        rd_lit(16'h8028, 64'h0, "R1 active");
        rd_lit(16'h8038, 64'h0, "R1 done");
        rd_lit(16'h8040, 64'h0, "R1 cfg0");
        rd_lit(16'h80B8, 64'h0, "R1 val7");
        rd_lit(16'h80C0, 64'h0, "R1 fren");
        rd_lit(16'h80D8, 64'h0, "R1 frrd");

        // R2 start ignored outside manual mode
        wr_reg(16'h8028, 64'h1);
        rd_lit(16'h8028, 64'h0, "R2 start gated");
        wr_reg(16'h8020, 64'h1);
        rd_lit(16'h8020, 64'h1, "R2 mode readback");

        // R5 configuration layout
        wr_reg(16'h8058, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_lit(16'h8058, 64'h807F_FFFF_FFFF_FFFF, "R5 cfg3 fields");

        // R3 start
        sel4 = NE'(64'hF) << 26;
        wr_reg(16'h8040, {1'b1, 8'b0, sel4});
        wr_reg(16'h8028, 64'h1);
        rd_lit(16'h8028, 64'h2, "R3 active");
        rd_lit(16'h8080, 64'h0, "R3 cleared");

        // R6 counting with a 4-line field
        for (int c = 0; c < 3; c++)
            drive(1'b0, 1'b0, 16'h0, 64'h0, (NE'(1) << 26) | (NE'(1) << 28), 1'b0, 1'b0);
        for (int c = 0; c < 2; c++)
            drive(1'b0, 1'b0, 16'h0, 64'h0, NE'(1), 1'b0, 1'b0);
        rd_lit(16'h8080, 64'd3, "R6 field count");
        rd_lit(16'h8098, 64'd5, "R6 all lines");

        // R13 read data held between reads
        held = bus_rdata;
        drive(1'b0, 1'b0, 16'h8080, 64'h0, NE'(1) << 29, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 16'h8080, 64'h0, NE'(1) << 29, 1'b0, 1'b0);
        idle();
        check(bus_rdata, held, "R13 hold");
        rd_lit(16'h8080, 64'd5, "R13 next read");

        // R4 end
        wr_reg(16'h8030, 64'h1);
        rd_lit(16'h8038, 64'h1, "R4 done");
        rd_lit(16'h8028, 64'h0, "R4 inactive");
        rd_lit(16'h8030, 64'h0, "R4 end reads zero");
        for (int c = 0; c < 3; c++)
            drive(1'b0, 1'b0, 16'h0, 64'h0, NE'(1) << 27, 1'b0, 1'b0);
        rd_lit(16'h8080, 64'd5, "R4 frozen");
        wr_reg(16'h8030, 64'h1);
        rd_lit(16'h8038, 64'h1, "R4 end again ignored");

        // R8 value write ignored, R12 unmapped
        wr_reg(16'h8080, 64'hFF);
        rd_lit(16'h8080, 64'd5, "R8 value read-only");
        wr_reg(16'h8100, 64'hFFFF);
        rd_lit(16'h8100, 64'h0, "R12 unmapped");
        rd_lit(16'h8044, 64'h0, "R12 unaligned");

        // R3 restart and R7 saturation
        wr_reg(16'h8028, 64'h1);
        rd_lit(16'h8080, 64'h0, "R3 restart clears");
        rd_lit(16'h8038, 64'h0, "R3 done cleared");
        for (int c = 0; c < 300; c++)
            drive(1'b0, 1'b0, 16'h0, 64'h0, NE'(1) << 26, 1'b0, 1'b0);
        rd_lit(16'h8080, 64'd255, "R7 saturate cnt0");
        rd_lit(16'h8098, 64'd255, "R7 saturate cnt3");

        // R9 free-run counters independent of state
        wr_reg(16'h8030, 64'h1);
        wr_reg(16'h80C0, 64'h1);
        for (int c = 0; c < 5; c++)
            drive(1'b0, 1'b0, 16'h0, 64'h0, '0, 1'b1, 1'b1);
        rd_lit(16'h80D0, 64'd5, "R9 write count");
        rd_lit(16'h80D8, 64'd0, "R9 read disabled");

        // R11 wrap and sticky overflow
        wr_reg(16'h80C0, 64'h3);
        for (int c = 0; c < 130; c++)
            drive(1'b0, 1'b0, 16'h0, 64'h0, '0, 1'b1, 1'b1);
        rd_lit(16'h80D0, 64'h87, "R11 write wrap");
        rd_lit(16'h80D8, 64'h82, "R11 read wrap");

        // R10 clear wins over pulse
        drive(1'b1, 1'b0, 16'h80C8, 64'h1, '0, 1'b1, 1'b1);
        rd_lit(16'h80D0, 64'h0, "R10 write cleared");
        rd_lit(16'h80D8, 64'h83, "R10 read kept");
        rd_lit(16'h80C8, 64'h0, "R10 ctrl reads zero");

        // random phase
        for (int it = 0; it < 4000; it++) begin
            int r;
            int n;
            r = int'($urandom % 100);
            n = int'($urandom % NP);
            if (r < 5)
                wr_reg(16'(16'h8040 + 8 * n),
                       {1'($urandom), 8'b0, NE'({$urandom, $urandom}) & NE'({$urandom, $urandom})});
            else if (r < 7) wr_reg(16'h80C0, 64'($urandom % 4));
            else if (r < 8) wr_reg(16'h8028, 64'h1);
            else if (r < 9) wr_reg(16'h8030, 64'h1);
            else if (r < 10) wr_reg(16'h80C8, 64'($urandom % 4));
            else if (r < 12) rd_check(16'(16'h8040 + 8 * n), "R5 random cfg");
            else if (r < 16) rd_check(16'(16'h8080 + 8 * n), "R6 random count");
            else if (r < 17) rd_check(16'h8028, "R3 random active");
            else if (r < 18) rd_check(16'h8038, "R4 random done");
            else if (r < 19) rd_check(16'h80D0, "R11 random write count");
            else if (r < 20) rd_check(16'h80D8, "R11 random read count");
            else
                drive(1'b0, 1'b0, 16'h0, 64'h0,
                      NE'({$urandom, $urandom}) & NE'({$urandom, $urandom}) & NE'({$urandom, $urandom}),
                      1'($urandom), 1'($urandom));
        end
        for (int n = 0; n < NP; n++)
            rd_check(16'(16'h8080 + 8 * n), "R6 final count");

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule